// File: doc/BRIEF.md
# ATA Device Select and Status Register Pair

This block is the device-side logic for two task-file registers of an ATA disk: the drive/head select byte and the status byte. A host register bus supplies a three-bit register offset, read and write strobes and a data byte. A write to the select offset stores the byte. The stored byte is then split into an addressing-mode flag, a target-device flag and a four-bit head field. In CHS mode the head field is the head number. In LBA mode it is LBA bits 27:24. When an initialize-parameters command runs, the command logic reads the same field as the maximum head index.

The unit compares the target-device flag with a strapped identity input to decide whether it answers. Only the answering unit drives read data, raises its interrupt line and takes a status read as an interrupt acknowledge. Command logic supplies the status byte inputs (busy, ready, fault, seek-complete, data-request, error) and a one-cycle pulse that raises the pending interrupt. A status read by the answering unit clears that pending interrupt.

Top module: `ata_taskfile_regs`

## Requirements
- R1: While `rst_n` is low at a clock edge, the stored select byte becomes 0x00 and the pending interrupt is cleared, so `intrq_o` is 0 after reset.
- R2: A write strobe at offset 6 stores `bus_wdata` at the clock edge. From the next cycle `lba_mode_o` is bit 6, `dev_sel_o` is bit 4 and `head_o` is bits 3:0 of the stored byte. Bits 7 and 5 have no function.
- R3: A read strobe at offset 6 by an answering unit returns the stored select byte unchanged, in the same cycle.
- R4: `selected_o` is 1 exactly when `dev_sel_o` equals `strap_slave` (0 = master, 1 = slave). An unit that is not selected holds `bus_rdata_oe` at 0 and `bus_rdata` at 0x00. Reads at offsets other than 6 and 7 also leave the bus undriven.
- R5: A read at offset 7 while not busy returns the bits BSY, DRDY, DF, DSC, DRQ, 0, 0, ERR, from bit 7 down to bit 0, taken from the status inputs.
- R6: A read at offset 7 while `busy_i` is 1 returns 0x80, with every other bit forced to 0.
- R7: A pulse on `irq_set_i` makes the interrupt pending from the next cycle. `intrq_o` is the pending flag ANDed with `selected_o`.
- R8: A read at offset 7 by a selected unit clears the pending interrupt at that edge, so `intrq_o` is 0 in the next cycle.
- R9: If `irq_set_i` and a clearing status read fall in the same cycle, the interrupt stays pending.
- R10: A status read by an unselected unit does not clear the pending interrupt. The interrupt reappears on `intrq_o` once the unit is selected again.
- R11: Writes at offsets other than 6, and all reads, leave the stored select byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_slave | input | 1 | Strapped identity: 0 master, 1 slave |
| bus_addr | input | 3 | Register offset on the host bus |
| bus_rd | input | 1 | Host read strobe |
| bus_wr | input | 1 | Host write strobe |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Read data, 0x00 when not driven |
| bus_rdata_oe | output | 1 | This unit drives read data |
| busy_i | input | 1 | Busy flag from command logic |
| ready_i | input | 1 | Ready flag |
| fault_i | input | 1 | Device-fault flag |
| seek_done_i | input | 1 | Seek-complete flag |
| drq_i | input | 1 | Data-request flag |
| err_i | input | 1 | Error flag |
| irq_set_i | input | 1 | One-cycle pulse that raises the interrupt |
| intrq_o | output | 1 | Interrupt request to the host |
| lba_mode_o | output | 1 | 1 = LBA addressing, 0 = CHS |
| dev_sel_o | output | 1 | Device flag from the select byte |
| head_o | output | 4 | Head number, or LBA bits 27:24 |
| selected_o | output | 1 | This unit answers the bus |

## Verification
The bench targets a set pulse and a status read landing in the same cycle. A design with the wrong priority would drop the interrupt and leave the host waiting. It targets status reads issued while the other device is selected: a design without the select gate would wrongly acknowledge, and lose, the interrupt of this unit. It also reads status while busy with every other flag set, which catches designs that leak stale DRQ or ERR. Writes at neighbouring offsets check that the select byte is decoded only at offset 6.

// File: rtl/ata_tf_pkg.sv
// Shared constants and types for the task-file register pair.
// Bit positions here are fixed by the host-visible register layout.
package ata_tf_pkg;
    localparam int TF_DATA_W   = 8;
    localparam int DH_LBA_BIT  = 6;
    localparam int DH_DEV_BIT  = 4;
    localparam int DH_HEAD_W   = 4;
    localparam int ST_BSY      = 7;
    localparam int ST_DRDY     = 6;
    localparam int ST_DF       = 5;
    localparam int ST_DSC      = 4;
    localparam int ST_DRQ      = 3;
    localparam int ST_ERR      = 0;

    typedef struct packed {
        logic busy;
        logic ready;
        logic fault;
        logic seek_done;
        logic drq;
        logic err;
    } tf_status_t;
endpackage

// File: rtl/ata_tf_devhead.sv
// Drive/head select register: stores the host byte and decodes its fields.
// Assumes the write enable is already qualified by the offset decode.
// Every unit on the cable stores the byte, whether or not it is selected.
module ata_tf_devhead
    import ata_tf_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [TF_DATA_W-1:0] wdata,
    input  logic                 strap_slave,
    output logic [TF_DATA_W-1:0] dh_q,
    output logic                 lba_mode,
    output logic                 dev_bit,
    output logic [DH_HEAD_W-1:0] head,
    output logic                 selected
);
    // Store the select byte on a qualified write.
    always_ff @(posedge clk) begin
        if (!rst_n)     dh_q <= '0;
        else if (wr_en) dh_q <= wdata;
    end

    // Field decode and the device match.
    assign lba_mode = dh_q[DH_LBA_BIT];
    assign dev_bit  = dh_q[DH_DEV_BIT];
    assign head     = dh_q[DH_HEAD_W-1:0];
    assign selected = (dev_bit == strap_slave);

    // R2: a write is visible in the next cycle
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> dh_q == $past(wdata));
    // R11: without a write the byte holds
    a_r11_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(dh_q));
endmodule

// File: rtl/ata_tf_status.sv
// Status byte assembly from the command-logic flags.
// While busy, only BSY is exposed, so no stale flags reach the host.
module ata_tf_status
    import ata_tf_pkg::*;
(
    input  tf_status_t           st_i,
    output logic [TF_DATA_W-1:0] status_byte
);
    // Build the byte; bits 2:1 always read zero.
    always_comb begin
        status_byte = '0;
        if (st_i.busy) begin
            status_byte[ST_BSY] = 1'b1;
        end else begin
            status_byte[ST_DRDY] = st_i.ready;
            status_byte[ST_DF]   = st_i.fault;
            status_byte[ST_DSC]  = st_i.seek_done;
            status_byte[ST_DRQ]  = st_i.drq;
            status_byte[ST_ERR]  = st_i.err;
        end
    end
endmodule

// File: rtl/ata_tf_irq.sv
// Pending-interrupt flag: a set pulse raises it and an acknowledge clears it.
// A set pulse wins over an acknowledge in the same cycle.
// Assumes the acknowledge is already gated by device selection.
module ata_tf_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set_pulse,
    input  logic ack,
    output logic pending
);
    // Update the flag; set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n)         pending <= 1'b0;
        else if (set_pulse) pending <= 1'b1;
        else if (ack)       pending <= 1'b0;
    end

    // R7 and R9: a set pulse always leaves the flag raised
    a_r7_set_raises: assert property (@(posedge clk) disable iff (!rst_n)
        set_pulse |=> pending);
    // R8: an acknowledge alone clears the flag
    a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !set_pulse) |=> !pending);
    // R10: without set or acknowledge the flag holds
    a_r10_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack && !set_pulse) |=> $stable(pending));
endmodule

// File: rtl/ata_taskfile_regs.sv
// Device-side drive/head select and status register pair of an ATA task file.
// Decodes the host bus offsets, gates all responses by the device match,
// and treats a selected status read as the interrupt acknowledge.
// Assumes strobes are one cycle wide and synchronous to clk.
module ata_taskfile_regs
    import ata_tf_pkg::*;
#(
    parameter int ADDR_W      = 3,
    parameter int DEVHEAD_OFS = 6,
    parameter int STATUS_OFS  = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 strap_slave,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_rd,
    input  logic                 bus_wr,
    input  logic [TF_DATA_W-1:0] bus_wdata,
    output logic [TF_DATA_W-1:0] bus_rdata,
    output logic                 bus_rdata_oe,
    input  logic                 busy_i,
    input  logic                 ready_i,
    input  logic                 fault_i,
    input  logic                 seek_done_i,
    input  logic                 drq_i,
    input  logic                 err_i,
    input  logic                 irq_set_i,
    output logic                 intrq_o,
    output logic                 lba_mode_o,
    output logic                 dev_sel_o,
    output logic [DH_HEAD_W-1:0] head_o,
    output logic                 selected_o
);
    localparam logic [ADDR_W-1:0] DH_ADDR = DEVHEAD_OFS[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] ST_ADDR = STATUS_OFS[ADDR_W-1:0];

    logic [TF_DATA_W-1:0] dh_q;
    logic [TF_DATA_W-1:0] status_byte;
    logic                 pending;
    logic                 hit_dh;
    logic                 hit_st;
    tf_status_t           st_flags;

    // Offset decode.
    assign hit_dh = (bus_addr == DH_ADDR);
    assign hit_st = (bus_addr == ST_ADDR);

    // Pack the status flags.
    assign st_flags = '{busy: busy_i, ready: ready_i, fault: fault_i,
                        seek_done: seek_done_i, drq: drq_i, err: err_i};

    ata_tf_devhead u_devhead (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (bus_wr && hit_dh),
        .wdata       (bus_wdata),
        .strap_slave (strap_slave),
        .dh_q        (dh_q),
        .lba_mode    (lba_mode_o),
        .dev_bit     (dev_sel_o),
        .head        (head_o),
        .selected    (selected_o)
    );

    ata_tf_status u_status (
        .st_i        (st_flags),
        .status_byte (status_byte)
    );

    ata_tf_irq u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_pulse (irq_set_i),
        .ack       (bus_rd && hit_st && selected_o),
        .pending   (pending)
    );

    // Read path: drive only when selected and the offset is one of ours.
    always_comb begin
        bus_rdata_oe = bus_rd && selected_o && (hit_dh || hit_st);
        bus_rdata    = '0;
        if (bus_rdata_oe) bus_rdata = hit_st ? status_byte : dh_q;
    end

    // Interrupt line is deasserted while another unit is selected.
    assign intrq_o = pending && selected_o;

    // R4: only a selected unit drives the bus
    a_r4_drive_selected: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata_oe |-> selected_o);
    // R4: an undriven bus reads zero
    a_r4_quiet_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rdata_oe |-> bus_rdata == '0);
    // R6: a busy status read exposes only BSY
    a_r6_busy_masks: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata_oe && hit_st && busy_i) |-> bus_rdata == 8'h80);
    // R10: interrupt line only from a selected unit
    a_r10_intrq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        intrq_o |-> selected_o);
endmodule

// File: tb/ata_taskfile_regs_test.sv
`timescale 1ns/1ps
module ata_taskfile_regs_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strap_slave = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       bus_rdata_oe;
    logic       busy_i = 0, ready_i = 0, fault_i = 0, seek_done_i = 0, drq_i = 0, err_i = 0;
    logic       irq_set_i = 0;
    logic       intrq_o, lba_mode_o, dev_sel_o, selected_o;
    logic [3:0] head_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [7:0] m_dh;
    logic       m_pend;

    always #4 clk = ~clk;

    ata_taskfile_regs uut (
        .clk(clk), .rst_n(rst_n), .strap_slave(strap_slave),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rdata_oe(bus_rdata_oe),
        .busy_i(busy_i), .ready_i(ready_i), .fault_i(fault_i),
        .seek_done_i(seek_done_i), .drq_i(drq_i), .err_i(err_i),
        .irq_set_i(irq_set_i), .intrq_o(intrq_o), .lba_mode_o(lba_mode_o),
        .dev_sel_o(dev_sel_o), .head_o(head_o), .selected_o(selected_o)
    );

    function automatic logic [7:0] exp_status(input logic b, r, f, s, d, e);
        if (b) return 8'h80;
        return {1'b0, r, f, s, d, 2'b00, e};
    endfunction

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
        end
    endtask

    // One bus cycle: drive at negedge, check combinational outputs, then advance the model.
    task automatic step(input logic rd, input logic wr, input logic [2:0] a,
                        input logic [7:0] wd, input logic set, input logic [5:0] st);
        logic       sel;
        logic [7:0] exp_rd;
        logic       exp_oe;
        @(negedge clk);
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd; irq_set_i = set;
        {busy_i, ready_i, fault_i, seek_done_i, drq_i, err_i} = st;
        #1;
        sel = (m_dh[4] == strap_slave);
        chk({7'd0, lba_mode_o}, {7'd0, m_dh[6]}, "R2 lba_mode");
        chk({7'd0, dev_sel_o},  {7'd0, m_dh[4]}, "R2 dev_sel");
        chk({4'd0, head_o},     {4'd0, m_dh[3:0]}, "R2 head");
        chk({7'd0, selected_o}, {7'd0, sel}, "R4 selected");
        chk({7'd0, intrq_o}, {7'd0, m_pend && sel}, sel ? "R7 intrq" : "R10 intrq gated");
        exp_oe = rd && sel && (a == 3'd6 || a == 3'd7);
        exp_rd = !exp_oe ? 8'h00 : (a == 3'd6) ? m_dh :
                 exp_status(st[5], st[4], st[3], st[2], st[1], st[0]);
        chk({7'd0, bus_rdata_oe}, {7'd0, exp_oe}, "R4 oe");
        if (!exp_oe)        chk(bus_rdata, exp_rd, "R4 quiet bus");
        else if (a == 3'd6) chk(bus_rdata, exp_rd, "R3 select readback");
        else if (st[5])     chk(bus_rdata, exp_rd, "R6 busy status");
        else                chk(bus_rdata, exp_rd, "R5 status byte");
        if (set)                              m_pend = 1'b1;
        else if (rd && a == 3'd7 && sel)      m_pend = 1'b0;
        if (wr && a == 3'd6)                  m_dh = wd;
        @(posedge clk);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0a7a));
        m_dh = 8'h00; m_pend = 1'b0;
        // R1: reset with a pending set pulse and a write attempt
        @(negedge clk); irq_set_i = 1; bus_wr = 1; bus_addr = 3'd6; bus_wdata = 8'hFF;
        repeat (3) @(posedge clk);
        @(negedge clk); irq_set_i = 0; bus_wr = 0;
        #1;
        chk({7'd0, intrq_o}, 8'h00, "R1 intrq after reset");
        chk({4'd0, head_o}, 8'h00, "R1 head after reset");
        chk({6'd0, lba_mode_o, dev_sel_o}, 8'h00, "R1 fields after reset");
        rst_n = 1;
        @(posedge clk);

        // R2/R3: LBA slave byte while strapped master: unit goes unselected
        step(0, 1, 3'd6, 8'h5A, 0, 6'b0);
        step(1, 0, 3'd7, 8'h00, 0, 6'b010001);        // R4 no drive
        step(0, 0, 3'd0, 8'h00, 1, 6'b0);             // R7 set while unselected
        step(1, 0, 3'd7, 8'h00, 0, 6'b0);             // R10 read must not clear
        step(0, 1, 3'd6, 8'hE3, 0, 6'b0);             // reselect, bits 7/5 stored
        step(0, 0, 3'd0, 8'h00, 0, 6'b0);             // R10 intrq reappears
        step(1, 0, 3'd6, 8'h00, 0, 6'b0);             // R3 readback
        // R9: set and acknowledge together, then R8 plain acknowledge
        step(1, 0, 3'd7, 8'h00, 1, 6'b010000);
        step(0, 0, 3'd0, 8'h00, 0, 6'b0);
        step(1, 0, 3'd7, 8'h00, 0, 6'b010000);
        step(0, 0, 3'd0, 8'h00, 0, 6'b0);
        // R6: busy masks every other flag
        step(1, 0, 3'd7, 8'h00, 0, 6'b111111);
        // R5: all non-busy flags
        step(1, 0, 3'd7, 8'h00, 0, 6'b011111);
        // R11: neighbouring offsets do not touch the select byte
        step(0, 1, 3'd5, 8'h1F, 0, 6'b0);
        step(0, 1, 3'd7, 8'h10, 0, 6'b0);
        step(1, 0, 3'd6, 8'h00, 0, 6'b0);
        // R4: read at an offset that is not ours
        step(1, 0, 3'd2, 8'h00, 0, 6'b0);

        // Random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [2:0] a;
            int op;
            if (i % 256 == 0) begin
                @(negedge clk); strap_slave = $urandom % 2;
            end
            op = $urandom % 8;
            a  = 3'd5 + 3'($urandom % 3);
            case (op)
                0, 1, 2: step(1, 0, a,     8'h00,        ($urandom % 6) == 0, 6'($urandom));
                3, 4:    step(0, 1, 3'd6,  8'($urandom), ($urandom % 6) == 0, 6'($urandom));
                5:       step(0, 1, 3'($urandom), 8'($urandom), 0, 6'($urandom));
                default: step(0, 0, a,     8'h00,        ($urandom % 6) == 0, 6'($urandom));
            endcase
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule